// File: doc/BRIEF.md
# Dual-Granularity Serial Bit Clock Divider

This block turns a reference clock into the bit clock of a serial peripheral port. It has two ways of choosing the division ratio. In the coarse mode, a 4-bit code selects a power of two. In the fine mode, an 8-bit extension is placed above the 4-bit code, and the resulting 12-bit value plus one gives any whole ratio from 1 to 4096.

The output stays at 50% duty for every ratio. For odd ratios, the active phase ends on a falling edge of the reference, which is done with a flop clocked on that edge. At ratio 1 the output is the reference clock itself, gated by the run state.

While the block is not running, the output rests at the level set by the polarity input. Alongside the clock it gives two one-cycle ticks, which mark where each output period begins and where it turns back to idle. A shift engine uses these ticks. The ratio is captured only while the block is stopped, so a word in progress never sees its bit rate change.

Top module: `spi_clkdiv`

## Requirements
- R1: With `fine_sel` low, the ratio N equals 2 to the power `div_code` (1 to 32768).
- R2: With `fine_sel` high, N equals the 12-bit value {`div_ext`,`div_code`} plus one (1 to 4096).
- R3: For even N, each output period is N reference cycles long. The active level lasts for the first N/2 cycles and the idle level for the rest.
- R4: For odd N of at least 3, the active level lasts exactly N reference half-cycles. It begins at a rising reference edge and ends at the falling reference edge in the middle of cycle floor(N/2).
- R5: For N equal to 1, `sclk` is active in the high half of every reference cycle while running, and idle in the low half.
- R6: The idle level of `sclk` equals `cpol` and the active level is its inverse. While stopped or in reset, `sclk` equals `cpol`.
- R7: The ratio is captured at every rising edge where `run_en` is low. Changes to `fine_sel`, `div_code` or `div_ext` while running have no effect until the next stopped edge.
- R8: Running begins with the first rising edge that samples `run_en` high. The first output period starts in the cycle after that edge. A rising edge that samples `run_en` low returns `sclk` to idle in the cycle that follows.
- R9: `lead_tick` is high for exactly the reference cycles that start an output period (cycle index 0 of each period) and low otherwise.
- R10: `trail_tick` is high for exactly the reference cycles of index floor(N/2) in each period, which is where the trailing edge occurs. It is low otherwise, and both ticks are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run request; ratio is frozen while high |
| cpol | input | 1 | Idle level of the bit clock |
| fine_sel | input | 1 | 0: power-of-two ratio, 1: unit-step ratio |
| div_code | input | 4 | Ratio code, low part of the fine ratio |
| div_ext | input | 8 | Upper part of the fine ratio |
| sclk | output | 1 | Serial bit clock |
| lead_tick | output | 1 | One-cycle marker of the period start |
| trail_tick | output | 1 | One-cycle marker of the trailing edge |

## Verification
The ticks and the coarse part of `sclk` are registered. They change in the reference cycle right after the rising edge that samples `run_en` or advances the period, so the reference model advances on each rising edge and compares in that same cycle. The odd-ratio and ratio-1 parts of `sclk` change at the falling reference edge. For this reason the bench samples `sclk` twice per cycle, in the middle of the high half and in the middle of the low half, and compares each sample against the half-cycle index the model predicts. Inputs change 2 ns after a rising edge, well clear of both sampling points.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_FINE = 1'b1
  } div_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_clkdiv_ratio.sv
module spi_clkdiv_ratio
  import spi_clkdiv_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int EXT_W   = 8,
  parameter int RATIO_W = 16
) (
  input  logic               mode_bit,
  input  logic [CODE_W-1:0]  code,
  input  logic [EXT_W-1:0]   ext,
  output logic [RATIO_W-1:0] ratio
);
  localparam int CAT_W = CODE_W + EXT_W;

  div_mode_e          mode;
  logic [CAT_W-1:0]   cat;
  logic [RATIO_W-1:0] pow_ratio;
  logic [RATIO_W-1:0] fine_ratio;

  always_comb begin
    mode       = div_mode_e'(mode_bit);
    cat        = {ext, code};
    pow_ratio  = RATIO_W'(1) << code;
    fine_ratio = RATIO_W'(cat) + RATIO_W'(1);
    ratio      = (mode == DIV_FINE) ? fine_ratio : pow_ratio;
  end
endmodule

// File: rtl/spi_clkdiv_count.sv
module spi_clkdiv_count #(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               run_q,
  output logic               pos_act,
  output logic               lead_q,
  output logic               trail_q
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half;
  logic               wrap;

  always_comb begin
    half = ratio_q >> 1;
    wrap = (cnt == ratio_q - RATIO_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= RATIO_W'(1);
      cnt     <= '0;
      run_q   <= 1'b0;
      pos_act <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_en) begin
      ratio_q <= ratio_in;
      cnt     <= '0;
      run_q   <= 1'b0;
      pos_act <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      pos_act <= (cnt < half);
      lead_q  <= (cnt == '0);
      trail_q <= (cnt == half);
      cnt     <= wrap ? '0 : cnt + RATIO_W'(1);
    end
  end
endmodule

// File: rtl/spi_clkdiv_shape.sv
module spi_clkdiv_shape #(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic               run_q,
  input  logic               pos_act,
  input  logic               cpol,
  output logic               sclk
);
  logic neg_act;
  logic is_one;
  logic is_odd;
  logic act;

  always_ff @(negedge clk) begin
    if (rst) neg_act <= 1'b0;
    else     neg_act <= pos_act;
  end

  always_comb begin
    is_one = (ratio_q == RATIO_W'(1));
    is_odd = ratio_q[0];
    if (is_one)      act = clk & run_q;
    else if (is_odd) act = pos_act | (neg_act & run_q);
    else             act = pos_act;
    sclk = cpol ^ act;
  end
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
  import spi_clkdiv_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              cpol,
  input  logic              fine_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic [EXT_W-1:0]  div_ext,
  output logic              sclk,
  output logic              lead_tick,
  output logic              trail_tick
);
  localparam int POW_W   = 1 << CODE_W;
  localparam int FINE_W  = CODE_W + EXT_W + 1;
  localparam int RATIO_W = int'(max_u(POW_W, FINE_W));

  logic [RATIO_W-1:0] ratio_d;
  logic [RATIO_W-1:0] ratio_q;
  logic               run_q;
  logic               pos_act;

  spi_clkdiv_ratio #(.CODE_W(CODE_W), .EXT_W(EXT_W), .RATIO_W(RATIO_W)) ratio_i (
    .mode_bit (fine_sel),
    .code     (div_code),
    .ext      (div_ext),
    .ratio    (ratio_d)
  );

  spi_clkdiv_count #(.RATIO_W(RATIO_W)) count_i (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .ratio_in (ratio_d),
    .ratio_q  (ratio_q),
    .run_q    (run_q),
    .pos_act  (pos_act),
    .lead_q   (lead_tick),
    .trail_q  (trail_tick)
  );

  spi_clkdiv_shape #(.RATIO_W(RATIO_W)) shape_i (
    .clk     (clk),
    .rst     (rst),
    .ratio_q (ratio_q),
    .run_q   (run_q),
    .pos_act (pos_act),
    .cpol    (cpol),
    .sclk    (sclk)
  );
endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk #(
  parameter int RATIO_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               run_en,
  input logic               cpol,
  input logic               sclk,
  input logic               lead_tick,
  input logic               trail_tick,
  input logic [RATIO_W-1:0] ratio_q
);
  // R8 / R6: a stopped edge returns the clock to its idle level
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (sclk == cpol));

  // R9 / R10: no ticks in the cycle after a stopped edge
  a_r10_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!lead_tick && !trail_tick));

  // R7: the captured ratio holds across running edges
  a_r7_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
    run_en |=> $stable(ratio_q));

  // R9: above ratio 1 the period-start tick lasts one cycle
  a_r9_lead_single: assert property (@(posedge clk) disable iff (rst)
    (lead_tick && ratio_q != RATIO_W'(1)) |=> !lead_tick);

  // R10: above ratio 1 the two ticks never coincide
  a_r10_ticks_apart: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != RATIO_W'(1)) |-> !(lead_tick && trail_tick));
endmodule

bind spi_clkdiv spi_clkdiv_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .cpol       (cpol),
  .sclk       (sclk),
  .lead_tick  (lead_tick),
  .trail_tick (trail_tick),
  .ratio_q    (ratio_q)
);

// File: tb/spi_clkdiv_tb_top.sv
module spi_clkdiv_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic       cpol = 1'b0;
  logic       fine_sel = 1'b0;
  logic [3:0] div_code = 4'd0;
  logic [7:0] div_ext = 8'd0;
  logic       sclk, lead_tick, trail_tick;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  string tag = "R6";

  bit m_run = 1'b0;
  int m_n   = 1;
  int m_cyc = 0;

  always #10 clk = ~clk;

  spi_clkdiv dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .cpol(cpol), .fine_sel(fine_sel),
    .div_code(div_code), .div_ext(div_ext),
    .sclk(sclk), .lead_tick(lead_tick), .trail_tick(trail_tick)
  );

  function automatic int model_ratio();
    if (fine_sel) return ((int'(div_ext) << 4) | int'(div_code)) + 1;
    return 1 << div_code;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at %0t: got %b expected %b (N=%0d cyc=%0d)", req, $time, act, exp, m_n, m_cyc);
    end
  endtask

  // Reference model: one step per rising edge, checks in both halves
  always @(posedge clk) begin
    logic e_hi, e_lo;
    if (rst) begin
      m_run = 1'b0; m_n = 1; m_cyc = 0;
    end else if (run_en) begin
      if (!m_run) begin m_run = 1'b1; m_cyc = 0; end
      else m_cyc = (m_cyc + 1) % m_n;
    end else begin
      m_run = 1'b0; m_n = model_ratio();
    end
    e_hi = m_run && (2 * m_cyc < m_n);
    e_lo = m_run && (2 * m_cyc + 1 < m_n);
    #5;
    check({tag, " R6 sclk high half"}, sclk, cpol ^ e_hi);
    check({tag, " R9 lead_tick"}, lead_tick, m_run && m_cyc == 0);
    check({tag, " R10 trail_tick"}, trail_tick, m_run && m_cyc == m_n / 2);
    #10;
    check({tag, " R6 sclk low half"}, sclk, cpol ^ e_lo);
  end

  task automatic seg(input string t, input bit fs, input int ext, input int code,
                     input bit pol, input int cycles);
    @(posedge clk); #2;
    run_en = 1'b0; fine_sel = fs; div_ext = 8'(ext); div_code = 4'(code); cpol = pol; tag = t;
    repeat (3) @(posedge clk);
    #2 run_en = 1'b1;
    repeat (cycles) @(posedge clk);
    #2 run_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    seg("R1 R5 R8", 1'b0, 0, 0, 1'b0, 20);
    seg("R1 R3", 1'b0, 0, 1, 1'b0, 20);
    seg("R1 R3", 1'b0, 0, 3, 1'b1, 40);
    seg("R1 R3", 1'b0, 0, 10, 1'b0, 2100);
    seg("R1 R3", 1'b0, 0, 15, 1'b1, 66000);
    seg("R2 R4", 1'b1, 0, 2, 1'b0, 30);
    seg("R2 R4", 1'b1, 0, 4, 1'b1, 30);
    seg("R2 R4", 1'b1, 1, 0, 1'b0, 60);
    seg("R2 R3", 1'b1, 255, 15, 1'b1, 8300);
    seg("R2 R5", 1'b1, 0, 0, 1'b1, 12);
    // R7: ratio inputs move mid-run and must be ignored
    @(posedge clk); #2;
    run_en = 1'b0; fine_sel = 1'b1; div_ext = 8'd0; div_code = 4'd6; cpol = 1'b0; tag = "R7";
    repeat (2) @(posedge clk);
    #2 run_en = 1'b1;
    repeat (10) @(posedge clk);
    #2 begin fine_sel = 1'b0; div_code = 4'd1; div_ext = 8'd9; end
    repeat (30) @(posedge clk);
    #2 run_en = 1'b0;
    repeat (2) @(posedge clk);
    #2 run_en = 1'b1;
    repeat (12) @(posedge clk);
    // R8: short stop mid-period with odd ratio
    #2 run_en = 1'b0; fine_sel = 1'b1; div_code = 4'd4; div_ext = 8'd0; tag = "R8 R4";
    @(posedge clk); #2 run_en = 1'b1;
    repeat (3) @(posedge clk); #2 run_en = 1'b0;
    @(posedge clk); #2 run_en = 1'b1;
    repeat (12) @(posedge clk); #2 run_en = 1'b0;
    // R6: idle level follows cpol
    tag = "R6";
    repeat (2) @(posedge clk); #2 cpol = 1'b1;
    repeat (2) @(posedge clk); #2 cpol = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule